// File: doc/BRIEF.md
# Open-Drain Byte-Level I2C Target

This block answers as a target device on a two-wire serial bus. Both bus lines first go through a two-flop synchronizer and a majority-free run-length filter, so nothing downstream ever sees a metastable or glitchy level. A small event decoder then turns the filtered lines into one-cycle pulses for clock rising edge, clock falling edge, START and STOP. A byte engine uses those pulses to take in a 7-bit address plus a direction bit, acknowledge when the address matches, and then either collect bytes from the controller or send bytes to it.

The data line is handled as an open-drain output. The output value pin is held at 0 at all times. The only thing the logic moves is the output enable: enable high pulls the line low, and enable low lets the pull-up raise it. Since only one signal ever changes, no skew between value and enable can put a short spike on the bus. The enable changes only while the filtered clock is low. A bus watchdog brings the engine back to idle if the clock line stops moving in the middle of a transfer.

On the local side, a received byte comes out with a one-cycle strobe, provided the local logic holds its ready input high. The byte to send is presented on an input and taken when a one-cycle load strobe fires. Two status outputs show whether a transfer is in progress and which direction was last addressed.

Top module: `i2c_od_slave`

## Requirements
- R1: Each bus line passes a two-flop synchronizer followed by a filter that only changes its output after FILT_LEN consecutive equal synchronized samples. An SCL or SDA pulse of 2 clocks (with FILT_LEN=4) is ignored, so it neither adds a bit nor forms a START or STOP.
- R2: A START (filtered SDA falling while filtered SCL is high) begins a new address phase with the bit counter cleared. This holds even when the START arrives in the middle of a byte (a repeated START).
- R3: `sda_o` is 0 in every cycle. The bus level is set only by `sda_oe`: 1 pulls SDA low and 0 releases it high.
- R4: SDA is sampled on the filtered SCL rising edge, most significant bit first. The first 7 bits of the address byte are the address and the 8th is the direction (1 = controller reads, 0 = controller writes).
- R5: After the 8th address bit, the block drives ACK (sda_oe = 1) for the ninth clock only if the 7 bits equal DEV_ADDR. On a mismatch it drives nothing, goes idle and ignores the bus until the next START. While address bits are arriving, sda_oe stays 0.
- R6: sda_oe is only ever raised while filtered SCL is low, that is, after a falling edge.
- R7: In a write, after each 8th data bit with `rx_ready` high, `rx_data` carries the byte together with a one-cycle `rx_valid`, and the block ACKs. With `rx_ready` low there is no strobe and no ACK, and the block goes idle.
- R8: In a read, `tx_data` is taken at the start of each byte with a one-cycle `tx_load`, and its bits are driven most significant bit first. SDA is released for the controller's ACK bit. A controller ACK (low) starts the next byte. A NACK (high) ends the transfer and the block goes idle.
- R9: A STOP (filtered SDA rising while filtered SCL is high) returns the block to idle with SDA released.
- R10: In any non-idle state, if filtered SCL stays unchanged for WDOG_CYCLES clocks, the block returns to idle and releases SDA. Shorter stalls leave the transfer intact.
- R11: `busy` is high from START until the transfer ends (STOP, address mismatch, refused byte, NACK or watchdog). `rd_mode` holds the direction bit of the last matched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| sda_o | output | 1 | Data pad output value, always 0 |
| sda_oe | output | 1 | Data pad enable; 1 pulls the bus low |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-cycle strobe: rx_data is new |
| rx_ready | input | 1 | Local side will accept the incoming byte |
| tx_data | input | 8 | Next byte to send to the controller |
| tx_load | output | 1 | One-cycle strobe: tx_data was taken |
| rd_mode | output | 1 | Direction bit of the last matched address |
| busy | output | 1 | A transfer is in progress |

## Verification
Two functions can act on the engine in the same cycle: the watchdog expiring, and a bus event (an SCL edge or a START) that should keep the transfer alive or restart it. The bench provokes this by parking SCL low in the middle of a write for half the watchdog limit and then for twice the limit, and once more while the block is driving an address ACK. It judges the outcome at the pins. After the short stall the next byte must still be strobed and acknowledged. After the long stalls `busy` and `sda_oe` must be low, a following byte must go unacknowledged, and a fresh START must bring the block back.

// File: rtl/i2c_od_pkg.sv
// Shared types for the open-drain I2C target.
package i2c_od_pkg;
    // Byte engine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } slv_state_e;
endpackage

// File: rtl/i2c_od_filter.sv
// Line conditioner: two-flop synchronizer plus run-length filter.
// Assumes: din is asynchronous; FILT_LEN >= 2. Output resets high (idle bus).
module i2c_od_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Synchronize, keep the recent history, and switch the output only on a uniform history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_od_events.sv
// Bus event decoder: SCL edges, START and STOP from the filtered lines.
// Assumes: both inputs come from i2c_od_filter and share its latency.
module i2c_od_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise = scl_f & ~scl_q;
        scl_fall = ~scl_f & scl_q;
        start_ev = scl_f & scl_q & sda_q & ~sda_f;
        stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_od_wdog.sv
// Bus watchdog: counts clocks without an SCL edge while a transfer is active.
// Assumes: LIMIT >= 2; expire is a one-cycle pulse.
module i2c_od_wdog #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic scl_edge,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Fire when the silent count reaches the limit.
    always_comb expire = active & ~scl_edge & (cnt_q == CW'(LIMIT - 1));

    // Count silent cycles; clear on edge, idle or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || scl_edge || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assert_wdog_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
endmodule

// File: rtl/i2c_od_slave.sv
// Open-drain I2C target, top level.
// Filters the bus, decodes events, and runs the address/byte engine.
// Assumes: SCL is never stretched, 7-bit addressing, a single controller.
module i2c_od_slave
    import i2c_od_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         FILT_LEN    = 4,
    parameter int         WDOG_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ready,
    input  logic [7:0] tx_data,
    output logic       tx_load,
    output logic       rd_mode,
    output logic       busy
);
    localparam int NLINES = 2;
    localparam int BITS   = 8;
    localparam int BCW    = $clog2(BITS + 1);

    logic [NLINES-1:0] raw_w, filt_w;
    logic              scl_f, sda_f;
    logic              scl_rise, scl_fall, start_ev, stop_ev, expire;
    slv_state_e        state_q;
    logic [BCW-1:0]    bit_cnt_q;
    logic [BITS-1:0]   shreg_q;
    logic              nack_q;

    assign raw_w = {sda_i, scl_i};
    assign scl_f = filt_w[0];
    assign sda_f = filt_w[1];

    // One conditioner per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_od_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_w[g]),
            .dout (filt_w[g])
        );
    end

    i2c_od_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    i2c_od_wdog #(.LIMIT(WDOG_CYCLES)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q != ST_IDLE),
        .scl_edge(scl_rise | scl_fall),
        .expire  (expire)
    );

    // Pad value fixed low; only the enable moves.
    assign sda_o = 1'b0;
    assign busy  = (state_q != ST_IDLE);

    // Byte engine: address, acknowledge, receive and transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            nack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            rd_mode   <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            tx_load   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
            if (start_ev) begin
                state_q   <= ST_ADDR;
                bit_cnt_q <= '0;
                sda_oe    <= 1'b0;
            end else if (stop_ev || expire) begin
                state_q <= ST_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg_q   <= {shreg_q[BITS-2:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall && bit_cnt_q == BCW'(BITS)) begin
                            if (state_q == ST_ADDR) begin
                                if (shreg_q[BITS-1:1] == DEV_ADDR) begin
                                    sda_oe  <= 1'b1;
                                    rd_mode <= shreg_q[0];
                                    state_q <= ST_ADDR_ACK;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else if (rx_ready) begin
                                rx_data  <= shreg_q;
                                rx_valid <= 1'b1;
                                sda_oe   <= 1'b1;
                                state_q  <= ST_RX_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_RX_ACK: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR_ACK && rd_mode) begin
                                shreg_q <= tx_data;
                                tx_load <= 1'b1;
                                sda_oe  <= ~tx_data[BITS-1];
                                state_q <= ST_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt_q == BCW'(BITS - 1)) begin
                                sda_oe    <= 1'b0;
                                bit_cnt_q <= '0;
                                state_q   <= ST_TX_ACK;
                            end else begin
                                shreg_q   <= shreg_q << 1;
                                sda_oe    <= ~shreg_q[BITS-2];
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_f;
                        end else if (scl_fall) begin
                            if (!nack_q) begin
                                shreg_q <= tx_data;
                                tx_load <= 1'b1;
                                sda_oe  <= ~tx_data[BITS-1];
                                state_q <= ST_TX;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: the enable only rises while the filtered clock is low.
    assert_oe_rise_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);
    // R2: a START restarts the address phase from bit zero.
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state_q == ST_ADDR && bit_cnt_q == '0));
    // R5: nothing is driven while address bits arrive.
    assert_addr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> !sda_oe);
    // R9: STOP returns to idle.
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !start_ev) |=> (state_q == ST_IDLE && !sda_oe));
    // R10: watchdog expiry returns to idle and releases the line.
    assert_wdog_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start_ev) |=> (state_q == ST_IDLE && !sda_oe));
    // R7: the receive strobe lasts one cycle.
    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8: the load strobe lasts one cycle.
    assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);
endmodule

// File: tb/sim_i2c_od_slave.sv
module sim_i2c_od_slave;
    localparam int Q  = 16;
    localparam int WD = 300;
    localparam logic [6:0] ADDR = 7'h42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic rx_ready = 1'b1;
    logic [7:0] tx_data;
    logic sda_bus;
    logic sda_o, sda_oe, rx_valid, tx_load, rd_mode, busy;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail = 0;
    int rx_count = 0;
    int load_count = 0;
    int scl_hi_run = 0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];
    logic [7:0] tx_arr [4] = '{8'h96, 8'h01, 8'hFF, 8'h5A};
    int tx_idx = 0;

    always #5 clk = ~clk;

    // Wired-AND bus: the pad pulls low only when enabled.
    assign sda_bus = m_sda & (sda_oe ? sda_o : 1'b1);

    i2c_od_slave #(.DEV_ADDR(ADDR), .FILT_LEN(4), .WDOG_CYCLES(WD)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_o(sda_o), .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_load(tx_load),
        .rd_mode(rd_mode), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock reference model: pad value, enable stability, local strobes.
    always @(negedge clk) begin
        if (!rst_n) begin
            tx_idx = 0;
            tx_data = tx_arr[0];
        end else begin
            check(sda_o == 1'b0, "R3 pad value", sda_o, 0);
            if (scl_hi_run >= 12)
                check(sda_oe == prev_oe, "R6 enable moved with SCL high", sda_oe, prev_oe);
            if (rx_valid) begin
                rx_count++;
                if (exp_rx.size() == 0)
                    check(0, "R7 unexpected rx_valid", rx_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_rx.pop_front();
                    check(rx_data == e, "R7 rx_data", rx_data, e);
                end
            end
            if (tx_load) begin
                load_count++;
                exp_tx.push_back(tx_data);
                tx_idx = (tx_idx + 1) % 4;
                tx_data = tx_arr[tx_idx];
            end
        end
        scl_hi_run = m_scl ? scl_hi_run + 1 : 0;
        prev_oe = sda_oe;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wait_n(Q);
        m_scl = 1'b1; wait_n(Q);
        m_sda = 1'b0; wait_n(Q);
        m_scl = 1'b0; wait_n(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wait_n(Q);
        m_scl = 1'b1; wait_n(Q);
        m_sda = 1'b1; wait_n(2 * Q);
    endtask

    // One bit; optional short glitches on SCL (low phase) and SDA (high phase).
    task automatic clk_bit(input bit b, input bit gl, output bit r);
        m_sda = b;
        if (gl) begin
            wait_n(4); m_scl = 1'b1; wait_n(2); m_scl = 1'b0; wait_n(Q - 6);
        end else wait_n(Q);
        m_scl = 1'b1;
        if (gl) begin
            wait_n(4); m_sda = 1'b0; wait_n(2); m_sda = b; wait_n(Q - 6);
        end else wait_n(Q);
        r = sda_bus;
        wait_n(Q);
        m_scl = 1'b0;
        wait_n(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit gl, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], gl && (i == 3), r);
        clk_bit(1'b1, 1'b0, r);
        ack = !r;
    endtask

    task automatic read_byte(input bit m_ack, output logic [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, r);
            d[i] = r;
        end
        clk_bit(!m_ack, 1'b0, r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        int c0;
        logic [7:0] d, e;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // Reset state (R3, R11).
        check(sda_oe == 0 && busy == 0 && rx_valid == 0 && tx_load == 0,
              "R11 reset outputs", {sda_oe, busy, rx_valid, tx_load}, 0);
        wait_n(20);

        // Write transfer (R4, R5, R7, R11, R9).
        i2c_start();
        write_byte({ADDR, 1'b0}, 0, ack);
        check(ack, "R5 address ACK", ack, 1);
        check(busy && !rd_mode, "R11 busy/rd_mode after write address", {busy, rd_mode}, 2);
        exp_rx.push_back(8'hA5);
        write_byte(8'hA5, 0, ack);
        check(ack, "R7 data ACK", ack, 1);
        exp_rx.push_back(8'h3C);
        write_byte(8'h3C, 0, ack);
        check(ack, "R7 data ACK 2", ack, 1);
        i2c_stop();
        check(!busy && !sda_oe, "R9 idle after STOP", {busy, sda_oe}, 0);
        check(rx_count == 2 && exp_rx.size() == 0, "R7 strobe count", rx_count, 2);

        // Wrong address (R5, R11).
        c0 = rx_count;
        i2c_start();
        write_byte({7'h43, 1'b0}, 0, ack);
        check(!ack, "R5 mismatch NACK", ack, 0);
        check(!busy, "R11 idle after mismatch", busy, 0);
        write_byte(8'h11, 0, ack);
        check(!ack && rx_count == c0, "R5 bus ignored after mismatch", rx_count, c0);
        i2c_stop();

        // Refused byte (R7).
        rx_ready = 1'b0;
        i2c_start();
        write_byte({ADDR, 1'b0}, 0, ack);
        check(ack, "R5 address ACK before refusal", ack, 1);
        write_byte(8'h55, 0, ack);
        check(!ack, "R7 refused byte NACK", ack, 0);
        check(!busy && rx_count == c0, "R7 no strobe, idle", rx_count, c0);
        i2c_stop();
        rx_ready = 1'b1;

        // Read transfer (R8, R4, R11).
        c0 = load_count;
        i2c_start();
        write_byte({ADDR, 1'b1}, 0, ack);
        check(ack && rd_mode, "R4 read address ACK and direction", {ack, rd_mode}, 3);
        for (int k = 0; k < 3; k++) begin
            read_byte(k != 2, d);
            e = (exp_tx.size() != 0) ? exp_tx.pop_front() : 8'hxx;
            check(d == e, "R8 read data", d, e);
        end
        check(!busy, "R8 idle after controller NACK", busy, 0);
        check(load_count - c0 == 3, "R8 load count", load_count - c0, 3);
        i2c_stop();

        // Repeated START mid-byte (R2).
        i2c_start();
        for (int i = 0; i < 3; i++) begin bit r; clk_bit(1'b1, 0, r); end
        i2c_start();
        write_byte({ADDR, 1'b0}, 0, ack);
        check(ack, "R2 ACK after repeated START", ack, 1);
        i2c_stop();

        // Glitches on both lines (R1).
        i2c_start();
        write_byte({ADDR, 1'b0}, 1, ack);
        check(ack, "R1 address ACK with glitches", ack, 1);
        exp_rx.push_back(8'h3C);
        write_byte(8'h3C, 1, ack);
        check(ack && busy, "R1 data survives glitches", {ack, busy}, 3);
        i2c_stop();
        check(exp_rx.size() == 0, "R1 byte delivered", exp_rx.size(), 0);

        // Watchdog: short stall survives, long stall recovers (R10).
        i2c_start();
        write_byte({ADDR, 1'b0}, 0, ack);
        wait_n(WD / 2);
        check(busy, "R10 busy after short stall", busy, 1);
        exp_rx.push_back(8'h77);
        write_byte(8'h77, 0, ack);
        check(ack, "R10 byte after short stall", ack, 1);
        wait_n(2 * WD);
        check(!busy && !sda_oe, "R10 idle after long stall", {busy, sda_oe}, 0);
        write_byte(8'h12, 0, ack);
        check(!ack, "R10 no ACK after timeout", ack, 0);
        i2c_stop();

        // Watchdog while driving ACK (R10, R5).
        i2c_start();
        begin
            logic [7:0] a;
            bit r;
            a = {ADDR, 1'b0};
            for (int i = 7; i >= 0; i--) clk_bit(a[i], 0, r);
        end
        check(sda_oe, "R5 ACK driven", sda_oe, 1);
        wait_n(2 * WD);
        check(!sda_oe && !busy, "R10 ACK released by watchdog", {sda_oe, busy}, 0);
        i2c_stop();
        i2c_start();
        write_byte({ADDR, 1'b1}, 0, ack);
        check(ack, "R10 recovery with new START", ack, 1);
        read_byte(1'b0, d);
        i2c_stop();
        void'(exp_tx.pop_front());

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule